// File: doc/BRIEF.md
# Fast-Clear Tag Resolve Engine

This block keeps a small tag for every block of a main surface, where a block is a pair of 64-byte cache lines (128 bytes). A tag says whether the block holds real data, holds only the current clear color, or, when tags are two bits wide, holds compressed data. A bulk fast clear sets every tag to the clear value and records the clear color in a state register. It never writes the main surface. A read of a clear-tagged block returns the clear color straight from that register. Any other read goes to a simple synchronous memory that models the main surface.

Before a consumer that cannot interpret the tags may use the surface, a resolve command walks the tags in ascending block order. It writes the clear color into both lines of each clear-tagged block and then rewrites every tag to pass-through. A separate ambiguate command does the tag rewrite on its own. A tag-write command sets the tag of a single block, which is how rendering marks blocks as real or compressed data.

Top module: `fcc_tag_engine`

## Requirements
- R1: After reset, every tag is pass-through (0), the clear color is zero, `cmd_ready` is 1, `rd_busy` is 0, `mem_req` is 0 and `done` is 0. A read therefore returns main-surface data with `rd_resp_clear` at 0.
- R2: Command code 1 (fast clear) loads `cmd_color` as the clear color and sets every tag to all ones. It issues no memory write.
- R3: A read of line address `rd_addr` (line = block*2 + half) whose block tag is all ones returns the clear color with `rd_resp_clear` at 1. The response comes one cycle after the read is accepted, and the read issues no memory access.
- R4: A read of a block whose tag is not all ones issues a memory read of that line. The data returns on `rd_resp_data` in the cycle after the memory accepts the request (`mem_req` and `mem_ready` both high). With `mem_ready` held high, that is two cycles after the read is accepted.
- R5: Command code 0 (load color) replaces the clear color. Clear-tagged blocks then read back with the new color, and no memory write takes place.
- R6: Command code 2 (resolve) visits blocks in ascending order. For each clear-tagged block it writes the clear color to the even line and then to the odd line. A write request stays asserted with a stable address and data until `mem_ready` is high.
- R7: When the resolve walk ends, every tag becomes pass-through and `done` is high for exactly one cycle.
- R8: With 2-bit tags, tag 1 marks a compressed block. A read of such a block comes from memory with `rd_resp_comp` at 1, and a resolve leaves both of its lines unwritten.
- R9: Command code 3 (ambiguate) sets every tag to pass-through and writes no memory.
- R10: While a resolve or a memory read is in progress, `cmd_ready` is 0 and `rd_busy` is 1, so new reads and commands wait. A command presented in the same cycle as a read takes priority.
- R11: Command code 4 (tag write) sets the tag of block `cmd_blk` to `cmd_tag` and leaves every other tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 3 | 0 load color, 1 fast clear, 2 resolve, 3 ambiguate, 4 tag write |
| cmd_color | input | LINE_W | Clear color for codes 0 and 1 |
| cmd_blk | input | BLK_W | Block index for tag write |
| cmd_tag | input | TAG_W | Tag value for tag write |
| done | output | 1 | One-cycle pulse at the end of a resolve |
| rd_valid | input | 1 | Read request |
| rd_addr | input | AW | Line address of the read |
| rd_busy | output | 1 | Read is not accepted this cycle |
| rd_resp_valid | output | 1 | Read data present |
| rd_resp_data | output | LINE_W | Read data |
| rd_resp_clear | output | 1 | Data came from the clear color |
| rd_resp_comp | output | 1 | Block was tagged compressed |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory line address |
| mem_wdata | output | LINE_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | LINE_W | Read data, valid the cycle after acceptance |

## Verification
A clear-tagged read answers one cycle after acceptance. A main-surface read answers two cycles after acceptance when the memory does not stall, and one cycle after the memory accepts the request when it does. The scoreboard logs the cycle count at which each read is accepted, and its monitor samples at the falling edge and compares the elapsed count against the expected latency. Under random stalls it checks only the data. Resolve writes are logged at the memory model as they are accepted and compared, in order, against the list of lines derived from the tag pattern. The `done` pulse is counted at every falling edge.

// File: rtl/fcc_tag_engine.sv
module fcc_tag_engine #(
  parameter int NUM_BLOCKS = 16,
  parameter int TAG_W      = 2,
  parameter int LINE_W     = 512,
  localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int AW        = BLK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [LINE_W-1:0] cmd_color,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [TAG_W-1:0]  cmd_tag,
  output logic              done,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_busy,
  output logic              rd_resp_valid,
  output logic [LINE_W-1:0] rd_resp_data,
  output logic              rd_resp_clear,
  output logic              rd_resp_comp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata
);

  localparam logic [TAG_W-1:0] TAG_CLR  = '1;
  localparam logic [TAG_W-1:0] TAG_PASS = '0;
  localparam logic [TAG_W-1:0] TAG_COMP = TAG_W'(1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_WR0, S_WR1, S_RDREQ, S_RDRET} state_t;

  state_t              state;
  logic [TAG_W-1:0]    tags [NUM_BLOCKS];
  logic [LINE_W-1:0]   color;
  logic [BLK_W-1:0]    idx;
  logic [AW-1:0]       rd_addr_q;
  logic                rd_comp_q;
  logic                clr_q;
  logic                walk_end;
  logic [TAG_W-1:0]    rd_tag;

  assign rd_tag    = tags[rd_addr[AW-1:1]];
  assign cmd_ready = (state == S_IDLE);
  assign rd_busy   = (state != S_IDLE) || cmd_valid;
  assign walk_end  = (idx == LAST_BLK) &&
                     (((state == S_SCAN) && (tags[idx] != TAG_CLR)) ||
                      ((state == S_WR1) && mem_ready));

  assign mem_req   = (state == S_WR0) || (state == S_WR1) || (state == S_RDREQ);
  assign mem_we    = (state == S_WR0) || (state == S_WR1);
  assign mem_addr  = (state == S_RDREQ) ? rd_addr_q : {idx, state == S_WR1};
  assign mem_wdata = color;

  assign rd_resp_valid = clr_q || (state == S_RDRET);
  assign rd_resp_data  = clr_q ? color : mem_rdata;
  assign rd_resp_clear = clr_q;
  assign rd_resp_comp  = (state == S_RDRET) && rd_comp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      color     <= '0;
      idx       <= '0;
      rd_addr_q <= '0;
      rd_comp_q <= 1'b0;
      clr_q     <= 1'b0;
      done      <= 1'b0;
      for (int i = 0; i < NUM_BLOCKS; i++) tags[i] <= TAG_PASS;
    end else begin
      done  <= 1'b0;
      clr_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            case (cmd_op)
              3'd0: color <= cmd_color;
              3'd1: begin
                color <= cmd_color;
                for (int i = 0; i < NUM_BLOCKS; i++) tags[i] <= TAG_CLR;
              end
              3'd2: begin
                idx   <= '0;
                state <= S_SCAN;
              end
              3'd3: for (int i = 0; i < NUM_BLOCKS; i++) tags[i] <= TAG_PASS;
              3'd4: tags[cmd_blk] <= cmd_tag;
              default: ;
            endcase
          end else if (rd_valid) begin
            rd_addr_q <= rd_addr;
            rd_comp_q <= (TAG_W > 1) && (rd_tag == TAG_COMP);
            if (rd_tag == TAG_CLR) clr_q <= 1'b1;
            else state <= S_RDREQ;
          end
        end
        S_SCAN: begin
          if (tags[idx] == TAG_CLR) state <= S_WR0;
          else if (idx == LAST_BLK) state <= S_IDLE;
          else idx <= idx + 1'b1;
        end
        S_WR0: if (mem_ready) state <= S_WR1;
        S_WR1: begin
          if (mem_ready) begin
            if (idx == LAST_BLK) state <= S_IDLE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_SCAN;
            end
          end
        end
        S_RDREQ: if (mem_ready) state <= S_RDRET;
        S_RDRET: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (walk_end) begin
        done <= 1'b1;
        for (int i = 0; i < NUM_BLOCKS; i++) tags[i] <= TAG_PASS;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R6
  AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready && !mem_addr[0] |=> mem_req && mem_we && mem_addr == $past(mem_addr) + 1'b1); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_TAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tags[0] == TAG_PASS && tags[NUM_BLOCKS-1] == TAG_PASS); // R7
  AST_FILL_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !cmd_ready && rd_busy); // R10
  AST_FAST_CLEAR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 3'd1 |=> !(mem_req && mem_we)); // R2
  AST_RESP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> $past(rd_valid && !rd_busy) || $past(mem_req && mem_ready && !mem_we)); // R3
  AST_CLEAR_READ_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_clear |-> !$past(mem_req)); // R3

endmodule

// File: tb/fcc_tag_engine_bench.sv
module fcc_tag_engine_bench;
  localparam int NB = 16;
  localparam int TW = 2;
  localparam int LW = 512;
  localparam int BW = 4;
  localparam int AW = 5;
  localparam int NL = 2 * NB;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_op = 0;
  logic [LW-1:0] cmd_color = 0;
  logic [BW-1:0] cmd_blk = 0;
  logic [TW-1:0] cmd_tag = 0;
  logic done;
  logic rd_valid = 0;
  logic [AW-1:0] rd_addr = 0;
  logic rd_busy, rd_resp_valid, rd_resp_clear, rd_resp_comp;
  logic [LW-1:0] rd_resp_data;
  logic mem_req, mem_we, mem_ready = 1;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wdata, mem_rdata = 0;

  fcc_tag_engine #(.NUM_BLOCKS(NB), .TAG_W(TW), .LINE_W(LW)) u_fcc_tag_engine (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, done_cnt = 0;
  logic [LW-1:0] mem [NL];
  logic [LW-1:0] exp_mem [NL];
  int wlog [$];
  logic stall_en = 0;
  logic [7:0] lfsr = 8'h5a;

  typedef struct { logic [LW-1:0] data; logic clr; logic comp; int acc; int lat; string req; } item_t;
  item_t sb [$];

  function automatic logic [LW-1:0] pat(int a);
    return {16{32'hA5000000 + 32'(a)}};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wlog.push_back(int'(mem_addr));
      end else mem_rdata <= mem[mem_addr];
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall_en ? lfsr[0] : 1'b1;
    if (done) done_cnt++;
  end

  always @(negedge clk) begin
    if (rst_n && rd_resp_valid) begin
      if (sb.size() == 0) chk(0, "R4", "unexpected response", rd_resp_data, '0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(rd_resp_data == it.data, it.req, "read data", rd_resp_data, it.data);
        chk(rd_resp_clear == it.clr, it.req, "clear flag", LW'(rd_resp_clear), LW'(it.clr));
        chk(rd_resp_comp == it.comp, it.req, "compressed flag", LW'(rd_resp_comp), LW'(it.comp));
        if (it.lat >= 0)
          chk(cyc - it.acc == it.lat, it.req, "latency", LW'(cyc - it.acc), LW'(it.lat));
      end
    end
  end

  task automatic do_read(int a, logic [LW-1:0] d, logic clr, logic comp, int lat, string req);
    item_t it;
    @(negedge clk);
    rd_valid = 1;
    rd_addr = AW'(a);
    #1;
    while (rd_busy) begin @(negedge clk); #1; end
    it.data = d; it.clr = clr; it.comp = comp; it.acc = cyc; it.lat = lat; it.req = req;
    sb.push_back(it);
    @(posedge clk);
    #1 rd_valid = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_cmd(logic [2:0] op, logic [LW-1:0] c, int blk, logic [TW-1:0] t);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_color = c; cmd_blk = BW'(blk); cmd_tag = t;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 0;
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    chk(0, "R10", "watchdog expired", LW'(wd), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LW-1:0] c1, c2, c3;
    int wbase, exp_w [$];
    c1 = {16{32'h11112222}};
    c2 = {16{32'h3c3c5a5a}};
    c3 = {16{32'h0badf00d}};
    for (int i = 0; i < NL; i++) begin mem[i] = pat(i); exp_mem[i] = pat(i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !rd_busy && !mem_req && !done, "R1", "idle after reset",
        LW'({cmd_ready, rd_busy, mem_req, done}), LW'(4'b1000));
    do_read(3, pat(3), 0, 0, 2, "R1");
    do_read(6, pat(6), 0, 0, 2, "R4");

    wbase = wlog.size();
    do_cmd(3'd1, c1, 0, 0);
    do_read(0, c1, 1, 0, 1, "R2");
    do_read(31, c1, 1, 0, 1, "R3");
    chk(wlog.size() == wbase, "R2", "writes after fast clear", LW'(wlog.size()), LW'(wbase));

    do_cmd(3'd0, c2, 0, 0);
    do_read(5, c2, 1, 0, 1, "R5");
    chk(wlog.size() == wbase, "R5", "writes after color load", LW'(wlog.size()), LW'(wbase));

    do_cmd(3'd4, '0, 2, 2'd0);
    do_cmd(3'd4, '0, 5, 2'd1);
    do_read(4, pat(4), 0, 0, 2, "R11");
    do_read(6, c2, 1, 0, 1, "R11");
    do_read(10, pat(10), 0, 1, 2, "R8");

    stall_en = 1;
    done_cnt = 0;
    wbase = wlog.size();
    do_cmd(3'd2, '0, 0, 0);
    @(negedge clk);
    chk(rd_busy && !cmd_ready, "R10", "busy during resolve", LW'({rd_busy, cmd_ready}), LW'(2'b10));
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R7", "done pulses", LW'(done_cnt), 1);
    for (int b = 0; b < NB; b++)
      if (b != 2 && b != 5) begin
        exp_w.push_back(2 * b); exp_w.push_back(2 * b + 1);
        exp_mem[2 * b] = c2; exp_mem[2 * b + 1] = c2;
      end
    chk(wlog.size() - wbase == exp_w.size(), "R6", "resolve write count",
        LW'(wlog.size() - wbase), LW'(exp_w.size()));
    for (int i = 0; i < exp_w.size() && wbase + i < wlog.size(); i++)
      chk(wlog[wbase + i] == exp_w[i], "R6", "resolve write order", LW'(wlog[wbase + i]), LW'(exp_w[i]));
    for (int i = 0; i < NL; i++)
      chk(mem[i] == exp_mem[i], (i == 10 || i == 11) ? "R8" : "R6", "surface after resolve", mem[i], exp_mem[i]);

    do_read(0, c2, 0, 0, -1, "R7");
    do_read(10, pat(10), 0, 0, -1, "R7");
    do_read(7, c2, 0, 0, -1, "R4");

    stall_en = 0;
    wbase = wlog.size();
    do_cmd(3'd1, c3, 0, 0);
    do_cmd(3'd3, '0, 0, 0);
    do_read(1, c2, 0, 0, 2, "R9");
    do_read(4, pat(4), 0, 0, 2, "R9");
    chk(wlog.size() == wbase, "R9", "writes after ambiguate", LW'(wlog.size()), LW'(wbase));

    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R4", "responses outstanding", LW'(sb.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule